// File: doc/BRIEF.md
# Floor packet percentage monitor

This block watches a stream of per-packet delay samples and judges, window by window, how many packets crossed the network at or near the lowest delay seen. A window lasts a programmable number of ticks of an external timebase strobe. During the window the block tracks the smallest delay (the floor), counts every packet, and keeps the delay samples in a small buffer. When the window closes, a second pass compares each kept sample with the final floor. Samples whose delay is no more than the floor plus a programmable width `delta` count as floor packets.

After the second pass, a sequential divider turns the floor-packet count into a share of the window's total, in units of 0.01 %. All results appear together with a one-cycle `report_valid` strobe. A two-bank sample store lets the next window fill one bank while the closed window is read back from the other. This allows collection to resume in the very next cycle after a close.

Top module: `floor_pct_mon`

## Requirements
- R1: A window closes in the cycle that carries its `win_ticks`-th `tick` (a value of 0 acts as 1). A packet presented in that same cycle belongs to the closing window. A packet presented in the following cycle belongs to the next window. No report appears before the closing tick.
- R2: `rpt_floor` equals the smallest `pkt_delay` among all packets of the window, including packets that were not stored.
- R3: `rpt_floor_cnt` is the number of stored packets whose delay lies between `rpt_floor` and `rpt_floor + delta` inclusive. `delta` is sampled in the cycle after the close.
- R4: `rpt_pct` equals floor(`rpt_floor_cnt` × 10000 / `rpt_total`), so 1 means 0.01 % and 10000 means 100 %. It never exceeds 10000.
- R5: `rpt_total` counts every packet of the window, whether stored or not, saturating at its maximum.
- R6: Only the first DEPTH packets of a window (DEPTH = 16 by default) are stored and classified. If a window has more packets than that, `rpt_overflow` is 1; otherwise it is 0.
- R7: A window with no packets reports `rpt_floor` all ones, `rpt_floor_cnt` 0, `rpt_pct` 0 and `rpt_empty` 1. Otherwise `rpt_empty` is 0.
- R8: `report_valid` is high for exactly one cycle per closed window. The report outputs hold their values until the next report.
- R9: While `rst` is high and after it falls, `report_valid` is 0 and every report output is 0. The tick count restarts from zero.
- R10: A report follows its closing cycle within DEPTH + 40 cycles. A window must not close while the previous one is still being processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one count per high cycle |
| win_ticks | input | TICK_W | Window length in ticks |
| delta | input | 16 | Cluster width above the floor |
| pkt_valid | input | 1 | A delay sample is present |
| pkt_delay | input | 16 | Delay of the packet |
| report_valid | output | 1 | One-cycle strobe: report fields are new |
| rpt_floor | output | 16 | Minimum delay of the window |
| rpt_total | output | 12 | Packets in the window |
| rpt_floor_cnt | output | 12 | Packets within the cluster |
| rpt_pct | output | 14 | Floor share in 0.01 % units |
| rpt_empty | output | 1 | Window had no packets |
| rpt_overflow | output | 1 | Window exceeded the sample store |

## Verification
A window close and a packet arrival can fall in the same cycle. The packet in that cycle must join the closing window, and a packet one cycle later must start the next window's floor and count. The bench provokes this by putting a packet on the closing tick that becomes the new floor, followed at once by an even lower packet. It then judges both reports against floors and counts computed from its own per-window packet lists. Overflow windows are judged the same way: the floor comes from a packet that was never stored.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int DLY_W     = 16;
    localparam int CNT_W     = 12;
    localparam int PCT_W     = 14;
    localparam int PCT_FULL  = 10000;

    typedef logic [DLY_W-1:0] delay_t;
    typedef logic [CNT_W-1:0] count_t;
    typedef logic [PCT_W-1:0] pct_t;

    typedef struct packed {
        delay_t floor;
        count_t total;
        count_t stored;
        logic   ovf;
    } win_sum_t;

    typedef struct packed {
        win_sum_t sum;
        count_t   floor_cnt;
        pct_t     pct;
        logic     empty;
    } win_rpt_t;

    typedef enum logic [1:0] {
        CL_IDLE,
        CL_SCAN,
        CL_DIV
    } cl_state_t;

    function automatic logic in_cluster(delay_t d, delay_t fl, delay_t width);
        return ({1'b0, d} <= ({1'b0, fl} + {1'b0, width}));
    endfunction

endpackage

// File: rtl/fpm_window_acc.sv
module fpm_window_acc import fpm_pkg::*; #(
    parameter int DEPTH  = 16,
    parameter int TICK_W = 24,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [TICK_W-1:0] win_ticks,
    input  logic              pkt_valid,
    input  delay_t            pkt_delay,
    output logic              wr_en,
    output logic              wr_bank,
    output logic [AW-1:0]     wr_addr,
    output delay_t            wr_data,
    output logic              close_pulse,
    output logic              closed_bank,
    output win_sum_t          closed_sum
);

    logic [TICK_W-1:0] tick_cnt;
    logic              bank_q;
    win_sum_t          cur, nxt;
    logic              close;
    logic              room;

    assign close = tick && (({1'b0, tick_cnt} + 1'b1) >= {1'b0, win_ticks});
    assign room  = cur.stored < count_t'(DEPTH);

    assign wr_en   = pkt_valid && room;
    assign wr_bank = bank_q;
    assign wr_addr = cur.stored[AW-1:0];
    assign wr_data = pkt_delay;

    always_comb begin
        nxt = cur;
        if (pkt_valid) begin
            if (pkt_delay < cur.floor) nxt.floor = pkt_delay;
            if (cur.total != '1)       nxt.total = cur.total + 1'b1;
            if (room)                  nxt.stored = cur.stored + 1'b1;
            else                       nxt.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt    <= '0;
            bank_q      <= 1'b0;
            cur         <= '{floor: '1, total: '0, stored: '0, ovf: 1'b0};
            close_pulse <= 1'b0;
            closed_bank <= 1'b0;
            closed_sum  <= '{floor: '1, total: '0, stored: '0, ovf: 1'b0};
        end else begin
            close_pulse <= close;
            if (close) begin
                closed_sum  <= nxt;
                closed_bank <= bank_q;
                bank_q      <= ~bank_q;
                tick_cnt    <= '0;
                cur         <= '{floor: '1, total: '0, stored: '0, ovf: 1'b0};
            end else begin
                cur <= nxt;
                if (tick) tick_cnt <= tick_cnt + 1'b1;
            end
        end
    end

    assert_floor_monotone_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(close) |-> (cur.floor <= $past(cur.floor)));

    assert_stored_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (cur.stored <= count_t'(DEPTH)) && (cur.stored <= cur.total));

endmodule

// File: rtl/fpm_sample_bank.sv
module fpm_sample_bank import fpm_pkg::*; #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_bank,
    input  logic [AW-1:0] wr_addr,
    input  delay_t        wr_data,
    input  logic          rd_bank,
    input  logic [AW-1:0] rd_addr,
    output delay_t        rd_data
);

    delay_t rd_word [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        delay_t mem [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
        end
        assign rd_word[b] = mem[rd_addr];
    end

    assign rd_data = rd_word[rd_bank];

endmodule

// File: rtl/fpm_pct_div.sv
module fpm_pct_div #(
    parameter int NUM_W = 26,
    parameter int DEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);

    localparam int SW = $clog2(NUM_W + 1);

    logic             busy_q;
    logic [SW-1:0]    step_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] q_q;
    logic [DEN_W:0]   trial, rem_nxt;
    logic             ge;

    assign trial   = {rem_q, q_q[NUM_W-1]};
    assign ge      = trial >= {1'b0, den_q};
    assign rem_nxt = ge ? (trial - {1'b0, den_q}) : trial;
    assign quot    = q_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            step_q <= '0;
            rem_q  <= '0;
            den_q  <= '0;
            q_q    <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                step_q <= '0;
                rem_q  <= '0;
                den_q  <= den;
                q_q    <= num;
            end else if (busy_q) begin
                rem_q  <= rem_nxt[DEN_W-1:0];
                q_q    <= {q_q[NUM_W-2:0], ge};
                step_q <= step_q + 1'b1;
                if (step_q == SW'(NUM_W - 1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assert_rem_fits_R4: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (rem_nxt[DEN_W] == 1'b0));

    assert_start_idle_R10: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy_q);

endmodule

// File: rtl/fpm_classify.sv
module fpm_classify import fpm_pkg::*; #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  win_sum_t      sum_in,
    input  logic          bank_in,
    input  delay_t        delta,
    input  delay_t        rd_data,
    output logic          rd_bank,
    output logic [AW-1:0] rd_addr,
    output logic          done,
    output win_rpt_t      rpt
);

    localparam int NUM_W = CNT_W + PCT_W;

    cl_state_t        state_q;
    count_t           idx_q;
    count_t           fcnt_q;
    win_sum_t         sum_q;
    delay_t           delta_q;
    logic             bank_q;
    logic             div_start, div_done;
    logic [NUM_W-1:0] quot;
    pct_t             pct_val;

    assign rd_bank   = bank_q;
    assign rd_addr   = idx_q[AW-1:0];
    assign div_start = (state_q == CL_SCAN) && (idx_q >= sum_q.stored);

    fpm_pct_div #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (NUM_W'(fcnt_q) * NUM_W'(PCT_FULL)),
        .den   (sum_q.total),
        .done  (div_done),
        .quot  (quot)
    );

    always_comb begin
        if (sum_q.total == '0)              pct_val = '0;
        else if (quot > NUM_W'(PCT_FULL))   pct_val = pct_t'(PCT_FULL);
        else                                pct_val = quot[PCT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CL_IDLE;
            idx_q   <= '0;
            fcnt_q  <= '0;
            sum_q   <= '0;
            delta_q <= '0;
            bank_q  <= 1'b0;
            rpt     <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                CL_IDLE: if (start) begin
                    sum_q   <= sum_in;
                    bank_q  <= bank_in;
                    delta_q <= delta;
                    idx_q   <= '0;
                    fcnt_q  <= '0;
                    state_q <= CL_SCAN;
                end
                CL_SCAN: begin
                    if (idx_q < sum_q.stored) begin
                        if (in_cluster(rd_data, sum_q.floor, delta_q)) fcnt_q <= fcnt_q + 1'b1;
                        idx_q <= idx_q + 1'b1;
                    end else begin
                        state_q <= CL_DIV;
                    end
                end
                CL_DIV: if (div_done) begin
                    rpt.sum       <= sum_q;
                    rpt.floor_cnt <= fcnt_q;
                    rpt.pct       <= pct_val;
                    rpt.empty     <= (sum_q.total == '0);
                    done          <= 1'b1;
                    state_q       <= CL_IDLE;
                end
                default: state_q <= CL_IDLE;
            endcase
        end
    end

    assert_idle_at_close_R10: assert property (@(posedge clk) disable iff (rst)
        start |-> (state_q == CL_IDLE));

    assert_scan_floor_R3: assert property (@(posedge clk) disable iff (rst)
        ((state_q == CL_SCAN) && (idx_q < sum_q.stored)) |-> (rd_data >= sum_q.floor));

endmodule

// File: rtl/floor_pct_mon.sv
module floor_pct_mon import fpm_pkg::*; #(
    parameter int DEPTH  = 16,
    parameter int TICK_W = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic [TICK_W-1:0]      win_ticks,
    input  logic [fpm_pkg::DLY_W-1:0] delta,
    input  logic                   pkt_valid,
    input  logic [fpm_pkg::DLY_W-1:0] pkt_delay,
    output logic                   report_valid,
    output logic [fpm_pkg::DLY_W-1:0] rpt_floor,
    output logic [fpm_pkg::CNT_W-1:0] rpt_total,
    output logic [fpm_pkg::CNT_W-1:0] rpt_floor_cnt,
    output logic [fpm_pkg::PCT_W-1:0] rpt_pct,
    output logic                   rpt_empty,
    output logic                   rpt_overflow
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          wr_en, wr_bank, rd_bank;
    logic [AW-1:0] wr_addr, rd_addr;
    delay_t        wr_data, rd_data;
    logic          close_pulse, closed_bank;
    win_sum_t      closed_sum;
    win_rpt_t      rpt;

    fpm_window_acc #(.DEPTH(DEPTH), .TICK_W(TICK_W), .AW(AW)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .win_ticks   (win_ticks),
        .pkt_valid   (pkt_valid),
        .pkt_delay   (pkt_delay),
        .wr_en       (wr_en),
        .wr_bank     (wr_bank),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .close_pulse (close_pulse),
        .closed_bank (closed_bank),
        .closed_sum  (closed_sum)
    );

    fpm_sample_bank #(.DEPTH(DEPTH), .AW(AW)) u_bank (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_bank (rd_bank),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    fpm_classify #(.DEPTH(DEPTH), .AW(AW)) u_cls (
        .clk     (clk),
        .rst     (rst),
        .start   (close_pulse),
        .sum_in  (closed_sum),
        .bank_in (closed_bank),
        .delta   (delta),
        .rd_data (rd_data),
        .rd_bank (rd_bank),
        .rd_addr (rd_addr),
        .done    (report_valid),
        .rpt     (rpt)
    );

    assign rpt_floor     = rpt.sum.floor;
    assign rpt_total     = rpt.sum.total;
    assign rpt_floor_cnt = rpt.floor_cnt;
    assign rpt_pct       = rpt.pct;
    assign rpt_empty     = rpt.empty;
    assign rpt_overflow  = rpt.sum.ovf;

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        report_valid |=> !report_valid);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !report_valid |-> ($stable(rpt_floor) && $stable(rpt_pct) && $stable(rpt_total)));

    assert_empty_R7: assert property (@(posedge clk) disable iff (rst)
        (report_valid && rpt_empty) |-> ((rpt_pct == '0) && (rpt_floor == '1) && (rpt_floor_cnt == '0)));

    assert_pct_range_R4: assert property (@(posedge clk) disable iff (rst)
        report_valid |-> ((rpt_pct <= PCT_W'(PCT_FULL)) && (rpt_floor_cnt <= rpt_total)));

    assert_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (report_valid && rpt_overflow) |-> (rpt_total > CNT_W'(DEPTH)));

endmodule

// File: tb/sim_floor_pct_mon.sv
module sim_floor_pct_mon;
    import fpm_pkg::*;

    localparam int DEPTH = 16;
    localparam int WIN   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [23:0] win_ticks = 24'(WIN);
    delay_t      delta = '0;
    logic        pkt_valid = 1'b0;
    delay_t      pkt_delay = '0;
    logic        report_valid;
    delay_t      rpt_floor;
    count_t      rpt_total, rpt_floor_cnt;
    pct_t        rpt_pct;
    logic        rpt_empty, rpt_overflow;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int mq [512];
    int mn = 0;

    floor_pct_mon #(.DEPTH(DEPTH), .TICK_W(24)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .win_ticks(win_ticks), .delta(delta),
        .pkt_valid(pkt_valid), .pkt_delay(pkt_delay), .report_valid(report_valid),
        .rpt_floor(rpt_floor), .rpt_total(rpt_total), .rpt_floor_cnt(rpt_floor_cnt),
        .rpt_pct(rpt_pct), .rpt_empty(rpt_empty), .rpt_overflow(rpt_overflow)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, got %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input int d, input logic t);
        @(negedge clk);
        pkt_valid = v;
        pkt_delay = delay_t'(d);
        tick      = t;
    endtask

    task automatic push(input int d);
        mq[mn] = d;
        mn = mn + 1;
    endtask

    // Close a window after sending n packets held in pk; optional packet in the
    // closing cycle and optional packet in the cycle after it.
    task automatic run_window(input string tag, input int pk [512], input int n,
                              input bit close_en, input int close_d,
                              input bit carry_en, input int carry_d);
        int exp_floor, exp_total, exp_stored, exp_fc, exp_pct;
        bit seen, early;
        for (int i = 0; i < n; i++) begin
            drive(1'b1, pk[i], 1'b0);
            push(pk[i]);
        end
        for (int i = 0; i < WIN - 1; i++) begin
            drive(1'b0, 0, 1'b1);
            drive(1'b0, 0, 1'b0);
        end
        early = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (report_valid) early = 1'b1;
        end
        chk("R1", {tag, " no report before closing tick"}, int'(early), 0);
        drive(close_en, close_d, 1'b1);
        if (close_en) push(close_d);
        // expected results from the bench's own list
        exp_floor = 32'hFFFF;
        for (int i = 0; i < mn; i++) if (mq[i] < exp_floor) exp_floor = mq[i];
        exp_total  = mn;
        exp_stored = (mn < DEPTH) ? mn : DEPTH;
        exp_fc = 0;
        for (int i = 0; i < exp_stored; i++)
            if (mq[i] <= exp_floor + int'(delta)) exp_fc = exp_fc + 1;
        exp_pct = (exp_total == 0) ? 0 : (exp_fc * 10000) / exp_total;
        mn = 0;
        if (carry_en) begin
            drive(1'b1, carry_d, 1'b0);
            push(carry_d);
        end
        drive(1'b0, 0, 1'b0);
        seen = 1'b0;
        for (int i = 0; i < DEPTH + 40 && !seen; i++) begin
            if (report_valid) seen = 1'b1;
            else @(negedge clk);
        end
        chk("R10", {tag, " report arrived in time"}, int'(seen), 1);
        if (seen) begin
            chk("R2", {tag, " floor"}, int'(rpt_floor), exp_floor);
            chk("R5", {tag, " total"}, int'(rpt_total), exp_total);
            chk("R3", {tag, " floor count"}, int'(rpt_floor_cnt), exp_fc);
            chk("R4", {tag, " percentage"}, int'(rpt_pct), exp_pct);
            chk("R6", {tag, " overflow flag"}, int'(rpt_overflow), int'(exp_total > DEPTH));
            chk("R7", {tag, " empty flag"}, int'(rpt_empty), int'(exp_total == 0));
            @(negedge clk);
            chk("R8", {tag, " strobe one cycle"}, int'(report_valid), 0);
        end
    endtask

    task automatic test_reset();
        chk("R9", "report_valid in reset", int'(report_valid), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9", "report_valid after reset", int'(report_valid), 0);
        chk("R9", "floor after reset", int'(rpt_floor), 0);
        chk("R9", "pct after reset", int'(rpt_pct), 0);
        chk("R9", "empty after reset", int'(rpt_empty), 0);
    endtask

    task automatic test_basic();
        int pk [512];
        int fl;
        pk[0] = 100; pk[1] = 103; pk[2] = 150; pk[3] = 101; pk[4] = 200; pk[5] = 105;
        delta = 16'd5;
        run_window("basic", pk, 6, 1'b0, 0, 1'b0, 0);
        fl = int'(rpt_floor);
        repeat (10) @(negedge clk);
        chk("R8", "basic floor held", int'(rpt_floor), fl);
        chk("R4", "basic pct 66.66", int'(rpt_pct), 6666);
    endtask

    task automatic test_zero_delta();
        int pk [512];
        pk[0] = 50; pk[1] = 51; pk[2] = 50; pk[3] = 50;
        delta = 16'd0;
        run_window("zero delta", pk, 4, 1'b0, 0, 1'b0, 0);
        chk("R3", "zero delta count", int'(rpt_floor_cnt), 3);
    endtask

    task automatic test_empty();
        int pk [512];
        run_window("empty", pk, 0, 1'b0, 0, 1'b0, 0);
        chk("R7", "empty floor all ones", int'(rpt_floor), 16'hFFFF);
    endtask

    task automatic test_overflow();
        int pk [512];
        for (int i = 0; i < 20; i++) pk[i] = (i < DEPTH) ? 500 + i : 490;
        delta = 16'd10;
        run_window("overflow", pk, 20, 1'b0, 0, 1'b0, 0);
        chk("R6", "overflow pct 5.00", int'(rpt_pct), 500);
    endtask

    task automatic test_close_edge();
        int pk [512];
        pk[0] = 80; pk[1] = 90;
        delta = 16'd10;
        run_window("close cycle", pk, 2, 1'b1, 70, 1'b1, 60);
        chk("R1", "closing-cycle packet joins floor", int'(rpt_floor), 70);
        pk[0] = 65;
        run_window("after close", pk, 1, 1'b0, 0, 1'b0, 0);
        chk("R1", "next-cycle packet starts next window", int'(rpt_floor), 60);
        chk("R4", "full share", int'(rpt_pct), 10000);
    endtask

    task automatic test_small_share();
        int pk [512];
        pk[0] = 10;
        for (int i = 1; i < 400; i++) pk[i] = 1000;
        delta = 16'd0;
        run_window("quarter percent", pk, 400, 1'b0, 0, 1'b0, 0);
        chk("R4", "0.25 percent", int'(rpt_pct), 25);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        test_basic();
        test_zero_delta();
        test_empty();
        test_overflow();
        test_close_edge();
        test_small_share();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule